// File: doc/BRIEF.md
# Masked Windowed Word-Copy Engine

This block is a single-channel copy engine that moves 32-bit words from a source region to a destination region. The regions are walked in windows of 32 consecutive words. A 32-bit selection mask picks which word positions inside a window are actually transferred. The same mask is applied to every window. A scattered set of registers can therefore be read or written with one command instead of one command per register.

Software loads a source address, a destination address, the selection mask, a window count and an interrupt-enable flag, then pulses a start strobe. The engine carries out each selected word as a read followed by a write on a simple word-wide memory master port with request/grant handshaking. It raises a one-cycle completion interrupt when the walk finishes. Malformed addresses are refused at the start strobe and reported on an error flag.

Top module: `wincopy_dma`

## Requirements
- R1: After a synchronous reset, `stat_busy`, `stat_err`, `mem_req` and `irq_done` are all 0.
- R2: A window count value N (4 bits, 0 to 15) moves N+1 windows. Word w (0 to 31) of window k is read at `src + 128*k + 4*w` and, if selected, written at `dst + 128*k + 4*w`. Nothing beyond window N is touched.
- R3: Mask bit i (bit 0 being the lowest-addressed word) selects word i of every window. A word with a cleared bit is neither read nor written. Its destination keeps its old value.
- R4: For each selected word the engine issues one read at the source address and then one write of the returned data to the matching destination address. At most one read is outstanding. While waiting for grant, the request, address, direction and write data stay unchanged.
- R5: A start strobe with aligned addresses while idle sets `stat_busy` on the next cycle. `stat_busy` then stays high until completion. A start strobe while busy is ignored, and the running transfer finishes with its original settings.
- R6: A start strobe while idle with either address not 32-byte aligned (any of address bits 4:0 set) is refused. `stat_err` rises on the next cycle, `stat_busy` stays 0 and no memory access occurs. A later accepted start clears `stat_err`.
- R7: With the interrupt enable set, `irq_done` pulses high for exactly one cycle after the last write, while `stat_busy` is still high. `stat_busy` falls on the next cycle. With the enable clear, `irq_done` stays 0 and `stat_busy` still falls.
- R8: With an all-zero mask the engine makes no memory access but still walks every window, then completes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle command strobe |
| cfg_src | input | ADDR_W | Source byte address |
| cfg_dst | input | ADDR_W | Destination byte address |
| cfg_mask | input | 32 | Word-select mask, bit i for word i of each window |
| cfg_count | input | 4 | Windows to move, minus one |
| cfg_irq_en | input | 1 | Enable the completion pulse |
| stat_busy | output | 1 | Transfer in progress |
| stat_err | output | 1 | Last start strobe was refused for alignment |
| mem_req | output | 1 | Memory access request, held until grant |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
A slip in the position counters shows within one window as a write whose destination offset differs from the preceding read's source offset. It can also show as an access outside the N+1 windows. Both are caught at the moment of the offending grant. A wrong mask index shows on the first selected word as an access at an unselected position, and as wrong destination contents after completion. A sequencer stuck in a waiting state keeps `stat_busy` high and never pulses `irq_done`, which the bench sees within a few thousand cycles. A lost hold condition shows as an address or direction change on the cycle after an ungranted request.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
    localparam int WCD_WIN_WORDS  = 32;
    localparam int WCD_WORD_IDX_W = $clog2(WCD_WIN_WORDS);
    localparam int WCD_CNT_W      = 4;
    localparam int WCD_WORD_BYTES = 4;
    localparam int WCD_BYTE_LSB   = $clog2(WCD_WORD_BYTES);
    localparam int WCD_ALIGN_LSB  = 5;
    localparam int WCD_OFF_W      = WCD_CNT_W + WCD_WORD_IDX_W + WCD_BYTE_LSB;

    // Linear word position inside the transfer: window in the upper bits.
    typedef struct packed {
        logic [WCD_CNT_W-1:0]      win;
        logic [WCD_WORD_IDX_W-1:0] word;
    } wcd_pos_t;

    typedef enum logic [2:0] {
        WCD_IDLE,
        WCD_SCAN,
        WCD_RD_REQ,
        WCD_RD_WAIT,
        WCD_WR_REQ,
        WCD_DONE
    } wcd_state_e;

    function automatic logic wcd_aligned(input logic [WCD_ALIGN_LSB-1:0] low);
        return low == '0;
    endfunction

    function automatic logic [WCD_OFF_W-1:0] wcd_byte_off(input wcd_pos_t p);
        return {p, {WCD_BYTE_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/wcd_cmd_reg.sv
module wcd_cmd_reg
    import wcd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_start,
    input  logic [ADDR_W-1:0]         cfg_src,
    input  logic [ADDR_W-1:0]         cfg_dst,
    input  logic [WCD_WIN_WORDS-1:0]  cfg_mask,
    input  logic [WCD_CNT_W-1:0]      cfg_count,
    input  logic                      cfg_irq_en,
    input  logic                      xfer_done,
    output logic [ADDR_W-1:0]         src_q,
    output logic [ADDR_W-1:0]         dst_q,
    output logic [WCD_WIN_WORDS-1:0]  mask_q,
    output logic [WCD_CNT_W-1:0]      cnt_q,
    output logic                      irq_en_q,
    output logic                      busy_q,
    output logic                      err_q,
    output logic                      launch_q
);
    logic take;
    logic addr_ok;

    assign take    = cfg_start && !busy_q;
    assign addr_ok = wcd_aligned(cfg_src[WCD_ALIGN_LSB-1:0])
                  && wcd_aligned(cfg_dst[WCD_ALIGN_LSB-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= '0;
            dst_q    <= '0;
            mask_q   <= '0;
            cnt_q    <= '0;
            irq_en_q <= 1'b0;
            busy_q   <= 1'b0;
            err_q    <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (take && addr_ok) begin
                src_q    <= cfg_src;
                dst_q    <= cfg_dst;
                mask_q   <= cfg_mask;
                cnt_q    <= cfg_count;
                irq_en_q <= cfg_irq_en;
                busy_q   <= 1'b1;
                err_q    <= 1'b0;
                launch_q <= 1'b1;
            end else if (take) begin
                err_q <= 1'b1;
            end else if (xfer_done) begin
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wcd_walker.sv
module wcd_walker
    import wcd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     advance,
    input  logic [WCD_WIN_WORDS-1:0] mask,
    input  logic [WCD_CNT_W-1:0]     last_win,
    output wcd_pos_t                 pos,
    output logic                     word_on,
    output logic                     at_end
);
    localparam logic [WCD_WORD_IDX_W-1:0] LAST_WORD = WCD_WORD_IDX_W'(WCD_WIN_WORDS - 1);

    logic end_of_win;

    assign end_of_win = (pos.word == LAST_WORD);
    assign at_end     = end_of_win && (pos.win == last_win);
    assign word_on    = mask[pos.word];

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos <= '0;
        end else if (advance) begin
            if (end_of_win) begin
                pos.word <= '0;
                pos.win  <= pos.win + 1'b1;
            end else begin
                pos.word <= pos.word + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wcd_sequencer.sv
module wcd_sequencer
    import wcd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              word_on,
    input  logic              at_end,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] hold_data,
    output logic              advance,
    output logic              xfer_done
);
    wcd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        advance  = 1'b0;
        unique case (state)
            WCD_IDLE:    if (launch) state_nx = WCD_SCAN;
            WCD_SCAN: begin
                if (word_on) begin
                    state_nx = WCD_RD_REQ;
                end else if (at_end) begin
                    state_nx = WCD_DONE;
                end else begin
                    advance = 1'b1;
                end
            end
            WCD_RD_REQ:  if (mem_gnt) state_nx = WCD_RD_WAIT;
            WCD_RD_WAIT: if (mem_rvalid) state_nx = WCD_WR_REQ;
            WCD_WR_REQ: begin
                if (mem_gnt) begin
                    if (at_end) begin
                        state_nx = WCD_DONE;
                    end else begin
                        advance  = 1'b1;
                        state_nx = WCD_SCAN;
                    end
                end
            end
            WCD_DONE:    state_nx = WCD_IDLE;
            default:     state_nx = WCD_IDLE;
        endcase
    end

    assign mem_req   = (state == WCD_RD_REQ) || (state == WCD_WR_REQ);
    assign mem_we    = (state == WCD_WR_REQ);
    assign xfer_done = (state == WCD_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WCD_IDLE;
            hold_data <= '0;
        end else begin
            state <= state_nx;
            if (state == WCD_RD_WAIT && mem_rvalid) begin
                hold_data <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/wincopy_dma.sv
module wincopy_dma
    import wcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_start,
    input  logic [ADDR_W-1:0]        cfg_src,
    input  logic [ADDR_W-1:0]        cfg_dst,
    input  logic [WCD_WIN_WORDS-1:0] cfg_mask,
    input  logic [WCD_CNT_W-1:0]     cfg_count,
    input  logic                     cfg_irq_en,
    output logic                     stat_busy,
    output logic                     stat_err,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_gnt,
    input  logic                     mem_rvalid,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     irq_done
);
    logic [ADDR_W-1:0]        src_q, dst_q;
    logic [WCD_WIN_WORDS-1:0] mask_q;
    logic [WCD_CNT_W-1:0]     cnt_q;
    logic                     irq_en_q;
    logic                     launch;
    logic                     xfer_done;
    logic                     advance;
    logic                     word_on;
    logic                     at_end;
    wcd_pos_t                 pos;

    wcd_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cfg_start (cfg_start),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .cfg_mask  (cfg_mask),
        .cfg_count (cfg_count),
        .cfg_irq_en(cfg_irq_en),
        .xfer_done (xfer_done),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .mask_q    (mask_q),
        .cnt_q     (cnt_q),
        .irq_en_q  (irq_en_q),
        .busy_q    (stat_busy),
        .err_q     (stat_err),
        .launch_q  (launch)
    );

    wcd_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .restart (launch),
        .advance (advance),
        .mask    (mask_q),
        .last_win(cnt_q),
        .pos     (pos),
        .word_on (word_on),
        .at_end  (at_end)
    );

    wcd_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .word_on   (word_on),
        .at_end    (at_end),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .hold_data (mem_wdata),
        .advance   (advance),
        .xfer_done (xfer_done)
    );

    // Source and destination share one offset; the direction picks the base.
    assign mem_addr = (mem_we ? dst_q : src_q) + ADDR_W'(wcd_byte_off(pos));
    assign irq_done = xfer_done && irq_en_q;
endmodule

// File: rtl/wincopy_dma_chk.sv
module wincopy_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_start,
    input logic              stat_busy,
    input logic              stat_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              irq_done
);
    logic rd_open;

    always_ff @(posedge clk) begin
        if (rst)                              rd_open <= 1'b0;
        else if (mem_req && !mem_we && mem_gnt) rd_open <= 1'b1;
        else if (mem_rvalid)                  rd_open <= 1'b0;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && !mem_gnt |=> $stable(mem_wdata)); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_open |-> !mem_req); // R4
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> stat_busy); // R5
    AST_START_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        cfg_start && !stat_busy |=> stat_busy != stat_err); // R6
    AST_WORD_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00); // R2
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !irq_done); // R7
    AST_IRQ_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> stat_busy); // R7
    AST_IRQ_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !stat_busy); // R7
endmodule

bind wincopy_dma wincopy_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_start (cfg_start),
    .stat_busy (stat_busy),
    .stat_err  (stat_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rvalid(mem_rvalid),
    .irq_done  (irq_done)
);

// File: tb/wincopy_dma_test.sv
`timescale 1ns/1ps
module wincopy_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_mask = '0;
    logic [3:0]  cfg_count = '0;
    logic        cfg_irq_en = 1'b0;
    logic        stat_busy, stat_err, mem_req, mem_we, irq_done;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    wincopy_dma uut (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_mask(cfg_mask), .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en),
        .stat_busy(stat_busy), .stat_err(stat_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq_done(irq_done)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mem [0:4095];
    int rd_n, wr_n, pair_bad, proto_bad, rd_left;
    logic [31:0] cur_src, cur_dst, last_rd_off;
    logic [11:0] rd_idx;
    logic [7:0]  lfsr = 8'hA5;

    function automatic logic [31:0] seed_val(input int i);
        return 32'hD000_0000 ^ (i * 32'h0000_9E37);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: decides grants and returns read data on falling edges.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rvalid = 1'b0;
        if (rd_left > 0) begin
            rd_left--;
            if (rd_left == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[rd_idx];
            end
        end
        mem_gnt = 1'b0;
        if (mem_req) begin
            if (rd_left != 0 || mem_rvalid) proto_bad++;
            if (lfsr[0] | lfsr[1]) begin
                mem_gnt = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_n++;
                    if (mem_addr - cur_dst != last_rd_off) pair_bad++;
                end else begin
                    rd_idx      = mem_addr[13:2];
                    last_rd_off = mem_addr - cur_src;
                    rd_left     = lfsr[2] ? 2 : 1;
                    rd_n++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic init_mem();
        for (int i = 0; i < 4096; i++) mem[i] = seed_val(i);
        rd_n = 0; wr_n = 0; pair_bad = 0; proto_bad = 0;
    endtask

    task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] m,
                          input logic [3:0] c, input logic ie);
        @(negedge clk);
        cfg_src = s; cfg_dst = d; cfg_mask = m; cfg_count = c; cfg_irq_en = ie;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle(output int irqs, output int irq_busy_bad);
        int n = 0;
        irqs = 0; irq_busy_bad = 0;
        while (stat_busy && n < 5000) begin
            if (irq_done) irqs++;
            @(negedge clk);
            if (irqs > 0 && n > 0 && stat_busy && !irq_done) irq_busy_bad++;
            n++;
        end
        if (n >= 5000) begin
            n_chk++; n_bad++;
            $display("FAIL R7 busy stuck actual=1 expected=0");
        end
    endtask

    task automatic check_copy(input string tag, input logic [31:0] s, input logic [31:0] d,
                              input logic [31:0] m, input int c);
        int bad = 0;
        for (int k = 0; k <= c + 1; k++) begin
            for (int w = 0; w < 32; w++) begin
                int si = s / 4 + k * 32 + w;
                int di = d / 4 + k * 32 + w;
                logic [31:0] e = (k <= c && m[w]) ? seed_val(si) : seed_val(di);
                if (mem[di] !== e) bad++;
            end
        end
        chk({tag, " contents"}, bad, 0);
        chk({tag, " R4 reads"}, rd_n, $countones(m) * (c + 1));
        chk({tag, " R4 writes"}, wr_n, $countones(m) * (c + 1));
        chk({tag, " R4 read/write pairing"}, pair_bad, 0);
        chk({tag, " R4 single outstanding"}, proto_bad, 0);
    endtask

    task automatic run_xfer(input string tag, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] m, input logic [3:0] c, input logic ie);
        int irqs, ib;
        init_mem();
        cur_src = s; cur_dst = d;
        launch(s, d, m, c, ie);
        chk({tag, " R5 busy after start"}, stat_busy, 1);
        wait_idle(irqs, ib);
        chk({tag, " R7 irq pulses"}, irqs, ie ? 1 : 0);
        chk({tag, " R7 busy past irq"}, ib, 0);
        check_copy(tag, s, d, m, c);
    endtask

    task automatic t_reset();
        chk("R1 busy", stat_busy, 0);
        chk("R1 err", stat_err, 0);
        chk("R1 req", mem_req, 0);
        chk("R1 irq", irq_done, 0);
    endtask

    task automatic t_misalign();
        int irqs, ib;
        init_mem();
        launch(32'h0000_0210, 32'h0000_2000, 32'hFFFF_FFFF, 4'd0, 1'b1);
        chk("R6 err on src", stat_err, 1);
        chk("R6 no busy", stat_busy, 0);
        repeat (20) @(negedge clk);
        chk("R6 no access", rd_n + wr_n, 0);
        launch(32'h0000_0200, 32'h0000_2004, 32'hFFFF_FFFF, 4'd0, 1'b1);
        chk("R6 err on dst", stat_err, 1);
        chk("R6 no busy dst", stat_busy, 0);
        cur_src = 32'h200; cur_dst = 32'h2000;
        launch(32'h0000_0200, 32'h0000_2000, 32'h0000_0003, 4'd0, 1'b0);
        chk("R6 err cleared", stat_err, 0);
        wait_idle(irqs, ib);
        check_copy("R6 recovery", 32'h200, 32'h2000, 32'h3, 0);
    endtask

    task automatic t_busy_start();
        int irqs, ib, bad = 0;
        init_mem();
        cur_src = 32'h400; cur_dst = 32'h2400;
        launch(32'h0000_0400, 32'h0000_2400, 32'h0F00_F00F, 4'd1, 1'b1);
        repeat (6) @(negedge clk);
        cfg_src = 32'h0000_0000; cfg_dst = 32'h0000_3000; cfg_mask = 32'hFFFF_FFFF;
        cfg_count = 4'd3; cfg_irq_en = 1'b0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R5 err untouched", stat_err, 0);
        wait_idle(irqs, ib);
        chk("R5 one completion", irqs, 1);
        check_copy("R5 original cmd", 32'h400, 32'h2400, 32'h0F00_F00F, 1);
        for (int i = 0; i < 128; i++) if (mem[3072 + i] !== seed_val(3072 + i)) bad++;
        chk("R5 ignored region", bad, 0);
    endtask

    initial begin
        rd_left = 0;
        init_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_xfer("R2 one window full mask", 32'h0000_0000, 32'h0000_2000, 32'hFFFF_FFFF, 4'd0, 1'b1);
        run_xfer("R3 sparse mask three windows", 32'h0000_0120, 32'h0000_2200, 32'h8001_0402, 4'd2, 1'b1);
        run_xfer("R2 sixteen windows", 32'h0000_0000, 32'h0000_2000, 32'h0F0F_00F1, 4'd15, 1'b1);
        run_xfer("R8 empty mask", 32'h0000_0000, 32'h0000_2000, 32'h0000_0000, 4'd4, 1'b1);
        run_xfer("R7 irq disabled", 32'h0000_0080, 32'h0000_2080, 32'hAAAA_5555, 4'd1, 1'b0);
        t_misalign();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule